// File: doc/BRIEF.md
# Configuration Image CRC Checker

This block verifies a configuration image as it streams out of a serial EEPROM. A fetch engine, which lies outside this block, hands over one byte per strobe together with that byte's address. The block runs a 10-bit cyclic redundancy check over the protected part of the image. It also assembles the check value stored in the two bytes that follow the protected part. When the last check byte arrives, it reports whether the two values agree.

A check session opens with a start pulse and closes either when the final check byte is accepted or when the fetch engine signals the end of its transfer. Strobes outside a session do not reach the CRC. The result stays visible until the next session begins. The running CRC and the assembled stored value are both available as outputs for diagnosis.

Top module: `cfg_crc_check`

## Requirements
- R1: After reset, crcValue and storedCrc are zero, and crcMatch and checkDone are low.
- R2: A start pulse clears crcValue to zero and crcMatch to low on the following clock edge. A byte strobe in the same cycle as the start pulse is not accepted.
- R3: Inside a session, each accepted byte at addresses 0x00 to 0x4D updates crcValue, MSB first, using generator x^10 + x^3 + 1 (feedback mask 0x009). For each bit, the feedback is crcValue[9] XOR the data bit, and crcValue becomes {crcValue[8:0],0} XOR (feedback ? 0x009 : 0). Without an accepted byte or a start pulse, crcValue does not change.
- R4: The byte at address 0x4E is loaded into storedCrc[9:2] and is not folded into crcValue.
- R5: Bits 7:6 of the byte at address 0x4F are loaded into storedCrc[1:0]. Bits 5:0 of that byte have no effect on any output.
- R6: On the clock edge that accepts the byte at 0x4F, checkDone goes high for exactly one cycle. On that same edge, crcMatch takes the result of the comparison crcValue == storedCrc.
- R7: crcMatch holds its value until the next start pulse or the next completed check.
- R8: Byte strobes before the first start pulse, or after a check has completed, are ignored.
- R9: Asserting fetchEnd closes the session, so later byte strobes are ignored until the next start pulse.
- R10: Byte strobes with an address above 0x4F have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Opens a check session and clears the result |
| byteValid | input | 1 | Byte strobe |
| byteData | input | 8 | Image byte |
| byteAddr | input | 8 | Address of the image byte |
| fetchEnd | input | 1 | The fetch engine has finished and closes the session |
| crcValue | output | 10 | Running CRC over the protected bytes |
| storedCrc | output | 10 | Check value assembled from the two check bytes |
| crcMatch | output | 1 | Computed and stored CRC agreed at the last completion |
| checkDone | output | 1 | One-cycle completion pulse |

## Verification
The assertions check three rules on every cycle. The CRC never moves without a byte strobe or a start pulse, and it stays frozen once a check has completed. The completion pulse is never longer than one cycle. The match flag rises only together with completion. Only the bench scenarios can show that the CRC arithmetic follows the polynomial over whole images and that the odd split of the stored value is decoded correctly. They also show that the ignored low bits of the final byte, pre-start strobes, out-of-range addresses and an early fetch end really leave the outputs untouched.

// File: rtl/cfg_crc_pkg.sv
package cfg_crc_pkg;
  typedef struct packed {
    logic clear;
    logic feed;
    logic capHi;
    logic capLo;
    logic finish;
  } crcCtrl_t;
endpackage

// File: rtl/cfg_crc_ctrl.sv
module cfg_crc_ctrl
  import cfg_crc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_END = 'h4D,
  parameter int HI_ADDR  = 'h4E,
  parameter int LO_ADDR  = 'h4F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              byteValid,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic              fetchEnd,
  output crcCtrl_t          ctrl
);
  logic sessionOn;
  logic take;

  assign take = sessionOn && byteValid && !startPulse;

  always_comb begin
    ctrl        = '0;
    ctrl.clear  = startPulse;
    ctrl.feed   = take && (int'(byteAddr) <= DATA_END);
    ctrl.capHi  = take && (int'(byteAddr) == HI_ADDR);
    ctrl.capLo  = take && (int'(byteAddr) == LO_ADDR);
    ctrl.finish = ctrl.capLo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sessionOn <= 1'b0;
    else if (startPulse) sessionOn <= 1'b1;
    else if (fetchEnd || ctrl.finish) sessionOn <= 1'b0;
  end
endmodule

// File: rtl/cfg_crc_datapath.sv
module cfg_crc_datapath
  import cfg_crc_pkg::*;
#(
  parameter int              CRC_W  = 10,
  parameter logic [CRC_W-1:0] POLY  = 10'h009,
  localparam int             LO_W   = CRC_W - 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  crcCtrl_t         ctrl,
  input  logic [7:0]       byteData,
  output logic [CRC_W-1:0] crcValue,
  output logic [CRC_W-1:0] storedCrc,
  output logic             crcMatch,
  output logic             checkDone
);
  logic [CRC_W-1:0] crcReg, crcNext;
  logic [7:0]       hiReg;
  logic [LO_W-1:0]  loReg;

  always_comb begin
    crcNext = crcReg;
    for (int b = 7; b >= 0; b--) begin
      if (crcNext[CRC_W-1] ^ byteData[b])
        crcNext = {crcNext[CRC_W-2:0], 1'b0} ^ POLY;
      else
        crcNext = {crcNext[CRC_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg    <= '0;
      hiReg     <= '0;
      loReg     <= '0;
      crcMatch  <= 1'b0;
      checkDone <= 1'b0;
    end else begin
      checkDone <= ctrl.finish;
      if (ctrl.clear) begin
        crcReg   <= '0;
        hiReg    <= '0;
        loReg    <= '0;
        crcMatch <= 1'b0;
      end else begin
        if (ctrl.feed)  crcReg <= crcNext;
        if (ctrl.capHi) hiReg  <= byteData;
        if (ctrl.capLo) loReg  <= byteData[7:8-LO_W];
        if (ctrl.finish)
          crcMatch <= (crcReg == {hiReg, byteData[7:8-LO_W]});
      end
    end
  end

  assign crcValue  = crcReg;
  assign storedCrc = {hiReg, loReg};
endmodule

// File: rtl/cfg_crc_check.sv
module cfg_crc_check
  import cfg_crc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CRC_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic              fetchEnd,
  output logic [CRC_W-1:0]  crcValue,
  output logic [CRC_W-1:0]  storedCrc,
  output logic              crcMatch,
  output logic              checkDone
);
  crcCtrl_t ctrl;

  cfg_crc_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .byteValid(byteValid),
    .byteAddr(byteAddr), .fetchEnd(fetchEnd), .ctrl(ctrl)
  );

  cfg_crc_datapath #(.CRC_W(CRC_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .byteData(byteData),
    .crcValue(crcValue), .storedCrc(storedCrc), .crcMatch(crcMatch),
    .checkDone(checkDone)
  );
endmodule

// File: rtl/cfg_crc_check_sva.sv
module cfg_crc_check_sva #(
  parameter int CRC_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic             byteValid,
  input logic [CRC_W-1:0] crcValue,
  input logic             crcMatch,
  input logic             checkDone
);
  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (crcValue == '0) && !crcMatch && !checkDone);
  // R3
  crc_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!byteValid && !startPulse) |=> $stable(crcValue));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    checkDone |=> !checkDone);
  // R7
  match_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(crcMatch) |-> checkDone);
  // R8
  after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (checkDone && !startPulse) |=> $stable(crcValue));
endmodule

bind cfg_crc_check cfg_crc_check_sva #(.CRC_W(CRC_W)) sva_i (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .byteValid(byteValid),
  .crcValue(crcValue), .crcMatch(crcMatch), .checkDone(checkDone)
);

// File: tb/cfg_crc_check_tb.sv
module cfg_crc_check_tb_top;
  logic       clk = 0, rstN = 0;
  logic       startPulse = 0, byteValid = 0, fetchEnd = 0;
  logic [7:0] byteData = 0, byteAddr = 0;
  logic [9:0] crcValue, storedCrc;
  logic       crcMatch, checkDone;
  int vecs = 0, errs = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cfg_crc_check dut_i (.*);

  function automatic logic [9:0] refStep(logic [9:0] c, logic [7:0] d);
    for (int b = 7; b >= 0; b--) begin
      logic fb;
      fb = c[9] ^ d[b];
      c = {c[8:0], 1'b0} ^ (fb ? 10'h009 : 10'h000);
    end
    return c;
  endfunction

  function automatic logic [7:0] imgByte(int i, int seed);
    return 8'((i * 37 + seed * 11 + (i >> 2)) & 8'hFF);
  endfunction

  function automatic logic [9:0] imgCrc(int seed);
    logic [9:0] c = '0;
    for (int i = 0; i <= 'h4D; i++) c = refStep(c, imgByte(i, seed));
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) startPulse = 1;
    @(negedge clk) startPulse = 0;
  endtask

  task automatic sendByte(logic [7:0] a, logic [7:0] d);
    @(negedge clk) begin byteValid = 1; byteAddr = a; byteData = d; end
    @(negedge clk) byteValid = 0;
  endtask

  task automatic sendBody(int seed);
    for (int i = 0; i <= 'h4D; i++) sendByte(8'(i), imgByte(i, seed));
  endtask

  task automatic testReset();
    chk("R1 crc", crcValue, 0);
    chk("R1 stored", storedCrc, 0);
    chk("R1 match", crcMatch, 0);
    chk("R1 done", checkDone, 0);
  endtask

  task automatic testPreStart();
    sendByte(8'h00, 8'hA5);
    chk("R8 pre-start crc", crcValue, 0);
  endtask

  task automatic testImage(int seed, logic [5:0] junk, bit corrupt);
    logic [9:0] c = imgCrc(seed);
    logic [9:0] s = corrupt ? c ^ 10'h001 : c;
    pulseStart();
    chk("R2 cleared", crcValue, 0);
    sendBody(seed);
    chk("R3 crc", crcValue, c);
    sendByte(8'h4E, s[9:2]);
    chk("R4 not folded", crcValue, c);
    chk("R4 stored hi", storedCrc[9:2], s[9:2]);
    sendByte(8'h50, 8'hFF);
    chk("R10 crc", crcValue, c);
    chk("R10 stored", storedCrc, {s[9:2], 2'b00});
    sendByte(8'h4F, {s[1:0], junk});
    chk("R6 done", checkDone, 1);
    chk("R6 match", crcMatch, !corrupt);
    chk("R5 stored", storedCrc, s);
    @(negedge clk);
    chk("R6 single", checkDone, 0);
    sendByte(8'h10, 8'h77);
    chk("R8 after done", crcValue, c);
    repeat (3) @(negedge clk);
    chk("R7 hold", crcMatch, !corrupt);
  endtask

  task automatic testFetchEnd();
    pulseStart();
    sendByte(8'h00, 8'h81);
    @(negedge clk) fetchEnd = 1;
    @(negedge clk) fetchEnd = 0;
    sendByte(8'h01, 8'h3C);
    chk("R9 crc frozen", crcValue, refStep(10'h0, 8'h81));
    sendByte(8'h4F, 8'h00);
    chk("R9 no done", checkDone, 0);
  endtask

  task automatic testStartClearsMatch();
    chk("R7 before start", crcMatch, 1);
    @(negedge clk) begin startPulse = 1; byteValid = 1; byteAddr = 0; byteData = 8'hFF; end
    @(negedge clk) begin startPulse = 0; byteValid = 0; end
    chk("R2 match cleared", crcMatch, 0);
    chk("R2 same-cycle byte", crcValue, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testPreStart();
    testImage(0, 6'h00, 0);
    testImage(5, 6'h3F, 0);
    testImage(9, 6'h15, 1);
    testFetchEnd();
    testImage(3, 6'h2A, 0);
    testStartClearsMatch();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule